// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the host-facing register file of an I2C master. The host writes command words (a byte plus start and stop flags) into a command FIFO, and the bus engine drains them one at a time. Bytes the engine receives are pushed into a receive FIFO, and the host pops them by reading a data register. A read transfer is paced by the host, which writes one command word for each byte it expects to get back. Both FIFO fill levels can be read, so software can work out free space as depth minus level.

A status register combines two live "ready" conditions, compared against per-FIFO thresholds, with three sticky event flags: lost arbitration, NACK and receive overflow. The sticky flags are cleared by writing 1 to them. A separate enable register gates the status bits onto a single interrupt line. Status reads always return the raw bits. Clearing the core-enable bit flushes both FIFOs and tells the engine to go idle. Clearing the bit and then setting it again is the software reset sequence.

Top module: `i2c_regfront`

## Requirements
- R1: After a synchronous active-low reset, the control and interrupt-enable registers read 0, both levels read 0, `irq` is 0, `cmd_valid` is 0 and `eng_abort` is 1.
- R2: While enabled, a write to word address 0 pushes `reg_wdata[9:0]` into the command FIFO. Bit 9 is start, bit 8 is stop and bits 7:0 are data. The oldest word is shown on `cmd_word` with `cmd_valid` high and is popped on a cycle with `cmd_ready` high. The level reads at address 6.
- R3: A command write while the command FIFO holds DEPTH entries is dropped.
- R4: Reading address 1 returns the oldest received byte in bits 7:0 and pops it. When the FIFO is empty, the read returns 0 and changes nothing. The receive level reads at address 7.
- R5: A byte offered on `rx_valid` while the receive FIFO is full is discarded, and status bit 4 (overflow) is set.
- R6: Status bit 1 (receive ready) is high while the receive level is greater than the threshold in control bits 9:8. Status bit 0 (command ready) is high while the command level is at or below the threshold in control bits 5:4. A threshold of 0 means one receive entry, or an empty command FIFO.
- R7: While enabled, `ev_arb` sets status bit 2 and `ev_nack` sets bit 3. Writing 1 to bits 2 to 4 at address 4 clears them. Writing 0 leaves them unchanged. Writes to bits 0 and 1 have no effect.
- R8: `irq` is high exactly when some status bit at address 4 is set together with its bit in the enable register at address 3. The status read returns the bits without the enable applied.
- R9: While control bit 0 (enable) is 0, both FIFOs are held empty, `cmd_valid` is 0 and `eng_abort` is 1. Command writes, received bytes and engine events are ignored.
- R10: Bit 0 of address 5 (busy) is set while `eng_busy` is high or commands are still pending.
- R11: Control bit 1 drives `bus_fast` (0 selects standard speed, 1 selects fast speed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the receive-data address) |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cmd_valid | output | 1 | Command word available to the engine |
| cmd_word | output | 10 | Oldest command: start, stop, data |
| cmd_ready | input | 1 | Engine takes the command word |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_arb | input | 1 | Arbitration-lost pulse |
| ev_nack | input | 1 | NACK pulse |
| eng_busy | input | 1 | Engine not idle |
| eng_abort | output | 1 | Engine must return to idle |
| bus_fast | output | 1 | Fast-speed select |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so it is due in the same cycle the address is driven. A pop, push, register write or event takes effect at the next rising edge. The status bits, the levels and `irq` show the new value one edge after the stimulus. The bench drives inputs just after a falling edge and checks explicit reads a quarter period later, before the edge that pops. At every falling edge it compares the outputs with a queue-based model that has been advanced on the same rising edge.

// File: rtl/i2c_rf_pkg.sv
// Shared constants and types for the I2C register front end.
// Assumes word addressing on the host port; offsets below define the map.
package i2c_rf_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 10;
    localparam int IRQ_N  = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CMD    = 3'd0,
        A_RXDATA = 3'd1,
        A_CTRL   = 3'd2,
        A_IER    = 3'd3,
        A_ISR    = 3'd4,
        A_STAT   = 3'd5,
        A_CMDLVL = 3'd6,
        A_RXLVL  = 3'd7
    } reg_addr_e;

    // Status / enable bit positions
    localparam int B_CMDRDY = 0;
    localparam int B_RXRDY  = 1;
    localparam int B_ARB    = 2;
    localparam int B_NACK   = 3;
    localparam int B_RXOF   = 4;

    // Control bit positions
    localparam int C_EN      = 0;
    localparam int C_FAST    = 1;
    localparam int C_CTH_LSB = 4;
    localparam int C_RTH_LSB = 8;

    typedef struct packed {
        logic       start;
        logic       stop;
        logic [7:0] data;
    } cmd_word_t;
endpackage

// File: rtl/i2c_rf_fifo.sv
// Synchronous FIFO with level output and synchronous clear.
// Assumes DEPTH >= 2. A push while full is dropped even if a pop
// happens in the same cycle; a pop while empty is ignored.
module i2c_rf_fifo #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    timeunit 1ns; timeprecision 1ps;

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST     = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign rdata   = mem[rd_ptr];

    // Pointer and occupancy bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/i2c_rf_regs.sv
// Control and enable registers, host write decode and read mux.
// Read data is combinational from the current address; side effects
// (pushes, pops, clears) are emitted as single-cycle strobes.
module i2c_rf_regs
    import i2c_rf_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int TH_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [LVL_W-1:0]  cmd_lvl,
    input  logic [LVL_W-1:0]  rx_lvl,
    input  logic [7:0]        rx_head,
    input  logic              rx_empty,
    input  logic [IRQ_N-1:0]  isr,
    input  logic              busy,
    output logic              core_en,
    output logic              fast,
    output logic [TH_W-1:0]   cmd_th,
    output logic [TH_W-1:0]   rx_th,
    output logic [IRQ_N-1:0]  ier,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cmd_push,
    output logic              rx_pop,
    output logic [IRQ_N-1:0]  isr_w1c
);
    timeunit 1ns; timeprecision 1ps;

    reg_addr_e         addr;
    logic [DATA_W-1:0] ctrl_view;

    assign addr     = reg_addr_e'(reg_addr);
    assign cmd_push = reg_wr && (addr == A_CMD);
    assign rx_pop   = reg_rd && (addr == A_RXDATA);
    assign isr_w1c  = (reg_wr && (addr == A_ISR)) ? reg_wdata[IRQ_N-1:0] : '0;

    // Control and interrupt-enable register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en <= 1'b0;
            fast    <= 1'b0;
            cmd_th  <= '0;
            rx_th   <= '0;
            ier     <= '0;
        end else if (reg_wr) begin
            if (addr == A_CTRL) begin
                core_en <= reg_wdata[C_EN];
                fast    <= reg_wdata[C_FAST];
                cmd_th  <= reg_wdata[C_CTH_LSB +: TH_W];
                rx_th   <= reg_wdata[C_RTH_LSB +: TH_W];
            end
            if (addr == A_IER) ier <= reg_wdata[IRQ_N-1:0];
        end
    end

    // Assemble the control register readback.
    always_comb begin
        ctrl_view                        = '0;
        ctrl_view[C_EN]                  = core_en;
        ctrl_view[C_FAST]                = fast;
        ctrl_view[C_CTH_LSB +: TH_W]     = cmd_th;
        ctrl_view[C_RTH_LSB +: TH_W]     = rx_th;
    end

    // Read data selection by address.
    always_comb begin
        case (addr)
            A_RXDATA: reg_rdata = rx_empty ? '0 : {{(DATA_W-8){1'b0}}, rx_head};
            A_CTRL:   reg_rdata = ctrl_view;
            A_IER:    reg_rdata = {{(DATA_W-IRQ_N){1'b0}}, ier};
            A_ISR:    reg_rdata = {{(DATA_W-IRQ_N){1'b0}}, isr};
            A_STAT:   reg_rdata = {{(DATA_W-1){1'b0}}, busy};
            A_CMDLVL: reg_rdata = {{(DATA_W-LVL_W){1'b0}}, cmd_lvl};
            A_RXLVL:  reg_rdata = {{(DATA_W-LVL_W){1'b0}}, rx_lvl};
            default:  reg_rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[DATA_W-1:C_RTH_LSB+TH_W];
endmodule

// File: rtl/i2c_rf_irq.sv
// Interrupt status: two live ready conditions against thresholds and
// three sticky event flags with write-one-to-clear. A set and a clear
// in the same cycle leave the flag set. Output is status AND enable.
module i2c_rf_irq
    import i2c_rf_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int TH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] cmd_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [TH_W-1:0]  cmd_th,
    input  logic [TH_W-1:0]  rx_th,
    input  logic             set_arb,
    input  logic             set_nack,
    input  logic             set_rxof,
    input  logic [IRQ_N-1:0] w1c,
    input  logic [IRQ_N-1:0] ier,
    output logic [IRQ_N-1:0] isr,
    output logic             irq
);
    timeunit 1ns; timeprecision 1ps;

    logic arb_q, nack_q, rxof_q;

    // Sticky event flags: clear by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q  <= 1'b0;
            nack_q <= 1'b0;
            rxof_q <= 1'b0;
        end else begin
            arb_q  <= (arb_q  & ~w1c[B_ARB])  | set_arb;
            nack_q <= (nack_q & ~w1c[B_NACK]) | set_nack;
            rxof_q <= (rxof_q & ~w1c[B_RXOF]) | set_rxof;
        end
    end

    // Raw status vector with live ready levels.
    always_comb begin
        isr           = '0;
        isr[B_CMDRDY] = (cmd_lvl <= LVL_W'(cmd_th));
        isr[B_RXRDY]  = (rx_lvl > LVL_W'(rx_th));
        isr[B_ARB]    = arb_q;
        isr[B_NACK]   = nack_q;
        isr[B_RXOF]   = rxof_q;
    end

    assign irq = |(isr & ier);

    logic unused_live_w1c;
    assign unused_live_w1c = w1c[B_CMDRDY] ^ w1c[B_RXRDY];
endmodule

// File: rtl/i2c_regfront.sv
// Top of the I2C master register front end: register block, command
// FIFO toward the bus engine, receive FIFO from it, interrupt unit.
// Assumes 2 <= DEPTH <= 16 so thresholds fit their control fields.
module i2c_regfront
    import i2c_rf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_word,
    input  logic              cmd_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              ev_arb,
    input  logic              ev_nack,
    input  logic              eng_busy,
    output logic              eng_abort,
    output logic              bus_fast,
    output logic              irq
);
    timeunit 1ns; timeprecision 1ps;

    logic             core_en, flush;
    logic [TH_W-1:0]  cmd_th, rx_th;
    logic [IRQ_N-1:0] ier, isr, isr_w1c;
    logic             cmd_push, cmd_pop, cmd_full, cmd_empty;
    logic             rx_pop, rx_full, rx_empty;
    logic [LVL_W-1:0] cmd_lvl, rx_lvl;
    logic [7:0]       rx_head;
    cmd_word_t        cmd_in, cmd_out;
    logic             busy;

    assign flush     = ~core_en;
    assign eng_abort = flush;
    assign cmd_valid = core_en & ~cmd_empty;
    assign cmd_pop   = cmd_valid & cmd_ready;
    assign cmd_in    = cmd_word_t'(reg_wdata[CMD_W-1:0]);
    assign cmd_word  = cmd_out;
    assign busy      = eng_busy | ~cmd_empty;

    i2c_rf_regs #(.LVL_W(LVL_W), .TH_W(TH_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmd_lvl   (cmd_lvl),
        .rx_lvl    (rx_lvl),
        .rx_head   (rx_head),
        .rx_empty  (rx_empty),
        .isr       (isr),
        .busy      (busy),
        .core_en   (core_en),
        .fast      (bus_fast),
        .cmd_th    (cmd_th),
        .rx_th     (rx_th),
        .ier       (ier),
        .reg_rdata (reg_rdata),
        .cmd_push  (cmd_push),
        .rx_pop    (rx_pop),
        .isr_w1c   (isr_w1c)
    );

    i2c_rf_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_cmd_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (cmd_push),
        .wdata (cmd_in),
        .pop   (cmd_pop),
        .rdata (cmd_out),
        .level (cmd_lvl),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    i2c_rf_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (rx_valid),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_head),
        .level (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    i2c_rf_irq #(.LVL_W(LVL_W), .TH_W(TH_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_lvl  (cmd_lvl),
        .rx_lvl   (rx_lvl),
        .cmd_th   (cmd_th),
        .rx_th    (rx_th),
        .set_arb  (core_en & ev_arb),
        .set_nack (core_en & ev_nack),
        .set_rxof (core_en & rx_valid & rx_full),
        .w1c      (isr_w1c),
        .ier      (ier),
        .isr      (isr),
        .irq      (irq)
    );

    logic unused_cmd_full;
    assign unused_cmd_full = cmd_full;
endmodule

// File: rtl/i2c_regfront_chk.sv
// Property checker for i2c_regfront, attached by bind below.
// Observes host strobes, engine inputs and internal levels/status.
module i2c_regfront_chk #(
    parameter  int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             rx_valid,
    input logic             ev_arb,
    input logic             irq,
    input logic             core_en,
    input logic [LVL_W-1:0] cmd_lvl,
    input logic [LVL_W-1:0] rx_lvl,
    input logic [4:0]       isr,
    input logic [4:0]       ier
);
    timeunit 1ns; timeprecision 1ps;

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    // R9: disabled core leaves both FIFOs empty after the next edge
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> (cmd_lvl == '0 && rx_lvl == '0));

    // R3: a full command FIFO with no pop keeps its level
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && cmd_lvl == FULL_LVL && !(cmd_valid && cmd_ready)) |=> cmd_lvl == FULL_LVL);

    // R5: offering a byte to a full receive FIFO raises overflow
    a_r5_rxof_set: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && rx_valid && rx_lvl == FULL_LVL) |=> isr[4]);

    // R7: write-one clears arbitration flag when no new event arrives
    a_r7_w1c_arb: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4 && reg_wdata[2] && !(core_en && ev_arb)) |=> !isr[2]);

    // R8: nothing enabled means no interrupt
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == '0) |-> !irq);

    // R2: no command offered from an empty FIFO, levels bounded
    a_r2_no_valid_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lvl == '0) |-> !cmd_valid);
    a_r2_lvl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lvl <= FULL_LVL && rx_lvl <= FULL_LVL));
endmodule

bind i2c_regfront i2c_regfront_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rx_valid  (rx_valid),
    .ev_arb    (ev_arb),
    .irq       (irq),
    .core_en   (core_en),
    .cmd_lvl   (cmd_lvl),
    .rx_lvl    (rx_lvl),
    .isr       (isr),
    .ier       (ier)
);

// File: tb/i2c_regfront_tb.sv
// Bench: behavioural queue model advanced on each rising edge and
// compared at each falling edge, plus directed checks with fixed values.
module i2c_regfront_tb;
    timeunit 1ns; timeprecision 1ps;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [9:0]  cmd_word;
    logic        cmd_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        ev_arb = 1'b0, ev_nack = 1'b0, eng_busy = 1'b0;
    logic        eng_abort, bus_fast, irq;

    int    vectors = 0;
    int    fails = 0;
    bit    running = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    i2c_regfront #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .ev_arb(ev_arb),
        .ev_nack(ev_nack), .eng_busy(eng_busy), .eng_abort(eng_abort),
        .bus_fast(bus_fast), .irq(irq)
    );

    // ---------------- reference model ----------------
    int cq[$];
    int rq[$];
    bit m_en, m_fast, m_arb, m_nack, m_rxof;
    int m_cth, m_rth, m_ier;

    function automatic int m_isr();
        return (int'(m_rxof) << 4) | (int'(m_nack) << 3) | (int'(m_arb) << 2) |
               (int'(rq.size() > m_rth) << 1) | int'(cq.size() <= m_cth);
    endfunction

    function automatic int m_read(int a);
        case (a)
            1: return (rq.size() > 0) ? rq[0] : 0;
            2: return int'(m_en) | (int'(m_fast) << 1) | (m_cth << 4) | (m_rth << 8);
            3: return m_ier;
            4: return m_isr();
            5: return int'(eng_busy || cq.size() > 0);
            6: return cq.size();
            7: return rq.size();
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  csz, rsz;
        bit  pre_en;
        csz = cq.size();
        rsz = rq.size();
        pre_en = m_en;
        if (!rst_n) begin
            cq.delete(); rq.delete();
            m_en = 0; m_fast = 0; m_arb = 0; m_nack = 0; m_rxof = 0;
            m_cth = 0; m_rth = 0; m_ier = 0;
        end else begin
            if (reg_wr && reg_addr == 3'd4) begin
                if (reg_wdata[2]) m_arb = 0;
                if (reg_wdata[3]) m_nack = 0;
                if (reg_wdata[4]) m_rxof = 0;
            end
            if (pre_en) begin
                if (ev_arb) m_arb = 1;
                if (ev_nack) m_nack = 1;
                if (rx_valid && rsz == DEPTH) m_rxof = 1;
                if (cmd_ready && csz > 0) void'(cq.pop_front());
                if (reg_rd && reg_addr == 3'd1 && rsz > 0) void'(rq.pop_front());
                if (reg_wr && reg_addr == 3'd0 && csz < DEPTH) cq.push_back(int'(reg_wdata[9:0]));
                if (rx_valid && rsz < DEPTH) rq.push_back(int'(rx_byte));
            end else begin
                cq.delete(); rq.delete();
            end
            if (reg_wr && reg_addr == 3'd2) begin
                m_en = reg_wdata[0]; m_fast = reg_wdata[1];
                m_cth = int'(reg_wdata[5:4]); m_rth = int'(reg_wdata[9:8]);
            end
            if (reg_wr && reg_addr == 3'd3) m_ier = int'(reg_wdata[4:0]);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk({cur_tag, " irq (R8)"}, 32'(irq), 32'(m_isr() & m_ier) != 0 ? 32'd1 : 32'd0);
            chk({cur_tag, " cmd_valid (R2)"}, 32'(cmd_valid), 32'(m_en && cq.size() > 0));
            if (cmd_valid) chk({cur_tag, " cmd_word (R2)"}, 32'(cmd_word), 32'(cq.size() > 0 ? cq[0] : -1));
            chk({cur_tag, " bus_fast (R11)"}, 32'(bus_fast), 32'(m_fast));
            chk({cur_tag, " eng_abort (R9)"}, 32'(eng_abort), 32'(!m_en));
            chk({cur_tag, " rdata"}, reg_rdata, 32'(m_read(int'(reg_addr))));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk); #1;
        reg_rd = 1'b1; reg_addr = 3'(a);
        #1 chk(tag, reg_rdata, 32'(exp));
        @(negedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic rx_push(input int b);
        @(negedge clk); #1;
        rx_valid = 1'b1; rx_byte = 8'(b);
        @(negedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic pop_cmds(input int n);
        @(negedge clk); #1;
        cmd_ready = 1'b1;
        repeat (n) @(negedge clk);
        #1 cmd_ready = 1'b0;
    endtask

    task automatic pulse_arb();
        @(negedge clk); #1 ev_arb = 1'b1;
        @(negedge clk); #1 ev_arb = 1'b0;
    endtask

    task automatic pulse_nack();
        @(negedge clk); #1 ev_nack = 1'b1;
        @(negedge clk); #1 ev_nack = 1'b0;
    endtask

    task automatic sample_pt();
        @(negedge clk); #2;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
        running = 1;

        // R1 reset state
        cur_tag = "R1";
        rd(2, 0, "R1 ctrl");
        rd(3, 0, "R1 ier");
        rd(6, 0, "R1 cmd level");
        rd(7, 0, "R1 rx level");
        sample_pt();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 eng_abort", 32'(eng_abort), 1);
        chk("R1 cmd_valid", 32'(cmd_valid), 0);

        // R11 enable, fast, cmd threshold 1, rx threshold 0
        cur_tag = "R11";
        wr(2, 'h13);
        sample_pt();
        chk("R11 bus_fast", 32'(bus_fast), 1);
        rd(2, 'h13, "R11 ctrl readback");

        // R2/R3 command FIFO fill and drop
        cur_tag = "R2";
        wr(0, 'h2A0); wr(0, 'h011); wr(0, 'h022); wr(0, 'h033);
        cur_tag = "R3";
        wr(0, 'h144);
        rd(6, 4, "R3 cmd level after overfill");
        sample_pt();
        chk("R2 head word", 32'(cmd_word), 'h2A0);
        chk("R2 cmd_valid", 32'(cmd_valid), 1);
        cur_tag = "R6";
        rd(4, 0, "R6 cmd not ready above threshold");
        rd(5, 1, "R10 busy with pending commands");
        cur_tag = "R2";
        pop_cmds(1);
        rd(6, 3, "R2 cmd level after pop");
        sample_pt();
        chk("R2 next word", 32'(cmd_word), 'h011);
        pop_cmds(2);
        rd(4, 1, "R6 cmd ready at threshold");
        sample_pt();
        chk("R3 last word is 0x033", 32'(cmd_word), 'h033);
        pop_cmds(1);
        rd(6, 0, "R2 cmd drained");

        // R10 busy
        cur_tag = "R10";
        rd(5, 0, "R10 idle");
        @(negedge clk); #1 eng_busy = 1'b1;
        rd(5, 1, "R10 engine busy");
        @(negedge clk); #1 eng_busy = 1'b0;
        rd(5, 0, "R10 back to idle");

        // R5/R4 receive FIFO overfill and pops
        cur_tag = "R5";
        rx_push('h5A); rx_push('h6B); rx_push('h7C); rx_push('h8D); rx_push('h9E);
        rd(7, 4, "R5 rx level capped");
        rd(4, 'h13, "R5 overflow bit set");
        cur_tag = "R4";
        rd(1, 'h5A, "R4 pop 1");
        rd(1, 'h6B, "R4 pop 2");
        rd(1, 'h7C, "R4 pop 3");
        rd(1, 'h8D, "R4 pop 4");
        rd(1, 0, "R4 empty read");
        rd(7, 0, "R4 rx level empty");

        // R6 receive threshold 2
        cur_tag = "R6";
        wr(2, 'h213);
        rx_push('h01); rx_push('h02);
        rd(4, 'h11, "R6 rx not ready at threshold");
        rx_push('h03);
        rd(4, 'h13, "R6 rx ready above threshold");
        rd(1, 'h01, "R6 drain"); rd(1, 'h02, "R6 drain"); rd(1, 'h03, "R6 drain");

        // R7 write-one-to-clear
        cur_tag = "R7";
        wr(4, 'h00);
        rd(4, 'h11, "R7 zero write keeps");
        wr(4, 'h03);
        rd(4, 'h11, "R7 live bits ignore clear");
        wr(4, 'h10);
        rd(4, 'h01, "R7 overflow cleared");
        pulse_arb();
        rd(4, 'h05, "R7 arb set");
        pulse_nack();
        rd(4, 'h0D, "R7 nack set");
        wr(4, 'h04);
        rd(4, 'h09, "R7 arb cleared only");

        // R8 interrupt gating
        cur_tag = "R8";
        wr(3, 'h08);
        sample_pt();
        chk("R8 irq on nack", 32'(irq), 1);
        wr(3, 'h00);
        sample_pt();
        chk("R8 irq masked", 32'(irq), 0);
        rd(4, 'h09, "R8 raw status unmasked");
        wr(4, 'h08);
        wr(2, 'h13);
        wr(3, 'h02);
        sample_pt();
        chk("R8 no irq rx empty", 32'(irq), 0);
        rx_push('h77);
        sample_pt();
        chk("R8 irq rx ready", 32'(irq), 1);
        rd(1, 'h77, "R8 pop");
        sample_pt();
        chk("R8 irq drops", 32'(irq), 0);
        wr(3, 'h00);

        // R9 disable flushes and ignores
        cur_tag = "R9";
        wr(0, 'h0AA);
        rx_push('h12);
        rd(6, 1, "R9 cmd before flush");
        rd(7, 1, "R9 rx before flush");
        wr(2, 'h00);
        rd(6, 0, "R9 cmd flushed");
        rd(7, 0, "R9 rx flushed");
        sample_pt();
        chk("R9 eng_abort", 32'(eng_abort), 1);
        chk("R9 cmd_valid", 32'(cmd_valid), 0);
        wr(0, 'h055);
        rd(6, 0, "R9 cmd write ignored");
        rx_push('h34);
        rd(7, 0, "R9 rx ignored");
        pulse_arb();
        rd(4, 'h01, "R9 event ignored");
        wr(2, 'h11);
        rd(6, 0, "R9 re-enabled empty");
        sample_pt();
        chk("R11 standard speed", 32'(bus_fast), 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule